// File: doc/BRIEF.md
# Instruction Bus-Cycle Sequencer

This block sits between an 8-bit processor's instruction decoder and its bus cycle generator. After reset it requests an opcode fetch at the program counter. It then classifies the returned opcode and walks through the fixed, ordered list of machine cycles that the instruction needs. Each cycle is an opcode fetch, a memory read or a memory write. For every cycle it chooses the address source, which is one of:
- the program counter,
- the two operand bytes collected so far,
- an external register pair,
- the stack pointer.

The block also keeps the program counter and the stack pointer up to date. It adds up a running total of T-states, and it flags the end of each instruction.

The sequencer sees a small set of opcodes:
- register-to-register move
- move immediate
- load register pair immediate
- load accumulator direct
- store accumulator direct
- load accumulator through BC or DE
- unconditional jump
- call

Any other opcode is sequenced as a plain 4-T fetch. No arithmetic, flags or register file are modelled. Register-pair contents and the accumulator value arrive as inputs.

The bus cycle generator sees a level request, together with the cycle kind, the address and the write data. It answers with a one-cycle done pulse, which carries read data on reads and fetches. Wait states are any number of cycles between the request and the done pulse.

Top module: `bus_cycle_sequencer`

## Requirements
- R1: While reset is active, no cycle is requested, the program counter is 0x0000, the stack pointer equals its reset parameter (default 0x2000), the T-state total is 0 and the end-of-instruction flag is low.
- R2: The cycle kind is encoded 0 = opcode fetch, 1 = memory read and 2 = memory write; 3 is never issued. While a request waits for done, the kind, address and write data stay unchanged.
- R3: The program counter advances by one after every opcode fetch and after every operand-byte read taken at the program counter. A jump or call instead loads the target from the two operand bytes (low byte first) on the last target read.
- R4: A register-to-register move (0x40–0x7F) and any opcode outside the supported set each cost exactly one 4-T opcode fetch and no other bus cycle.
- R5: Move immediate (00ddd110, except 0x36) is a fetch followed by one read at the program counter, totalling 7 T-states.
- R6: Load register pair immediate (0x01, 0x11, 0x21, 0x31) is a fetch followed by two reads at consecutive program counter values, low byte first, totalling 10 T-states.
- R7: Load direct (0x3A) and store direct (0x32) are a fetch, two address-byte reads, then one read (load) or one write of the accumulator input (store) at the address just assembled, totalling 13 T-states.
- R8: Opcode 0x0A reads once at the BC pair input and 0x1A reads once at the DE pair input, each totalling 7 T-states.
- R9: Unconditional jump (0xC3) is a fetch plus two target reads, totalling 10 T-states, with no extra cycle to load the program counter.
- R10: Call (0xCD) is a 6-T fetch, then two writes, then two target reads, totalling 18 T-states. The writes push the return address (opcode address + 3): first the high byte at SP−1, then the low byte at SP−2. The stack pointer is decremented before each write and ends 2 below its start.
- R11: The end-of-instruction flag pulses for one cycle right after the done of an instruction's final bus cycle. In that cycle the program counter, stack pointer and T-state total already hold their post-instruction values, and the next opcode fetch is being requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycReq | output | 1 | Bus cycle request, held until done |
| cycKind | output | 2 | Cycle kind: 0 fetch, 1 read, 2 write |
| cycAddr | output | 16 | Address of the requested cycle |
| cycWrData | output | 8 | Data for write cycles |
| cycDone | input | 1 | One-cycle completion pulse from the bus cycle generator |
| cycRdData | input | 8 | Fetched opcode or read byte, valid with done |
| pairBC | input | 16 | BC register pair value |
| pairDE | input | 16 | DE register pair value |
| accIn | input | 8 | Accumulator value for store direct |
| pcOut | output | 16 | Program counter |
| spOut | output | 16 | Stack pointer |
| tCount | output | 32 | Running T-state total |
| instrDone | output | 1 | End-of-instruction pulse |

## Verification
The checker enforces four rules on every cycle:
- a waiting request holds its kind, address and data, and the kind value 3 never appears;
- the program counter moves by exactly one after each fetch;
- the stack pointer only holds or steps down by one;
- the T-state total grows only by 0, 3, 4 or 6, and an end-of-instruction pulse always meets a fetch request.

The per-opcode parts can only be shown by the bench program, which runs each supported opcode and one unsupported one under varying wait states. Those parts are the exact order of cycles, the address source picked for each step, the push byte order and return address, the jump and call targets, and the T-state total of every instruction.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;

  typedef enum logic [1:0] {CYC_FETCH = 2'd0, CYC_READ = 2'd1, CYC_WRITE = 2'd2} cyc_kind_e;

  typedef enum logic [2:0] {
    CL_NOP, CL_MVI, CL_LXI, CL_LDA, CL_STA, CL_LDAX, CL_JMP, CL_CALL
  } op_class_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_OPLO, ST_OPHI, ST_MEMRD, ST_MEMWR, ST_RPRD, ST_PUSHH, ST_PUSHL
  } step_e;

  typedef enum logic [2:0] {A_PC, A_OPND, A_BC, A_DE, A_SP} addr_sel_e;
  typedef enum logic [1:0] {W_ACC, W_RETHI, W_RETLO} wr_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      pcInc;
    logic      pcLoad;
    logic      spDec;
    logic      opLoLd;
    logic      opHiLd;
    logic [2:0] tAdd;
    addr_sel_e addrSel;
    wr_sel_e   wrSel;
  } ctl_s;

  function automatic op_class_e decodeOp(input logic [DATA_W-1:0] op);
    op_class_e c;
    c = CL_NOP;
    if (op == 8'h3A) c = CL_LDA;
    else if (op == 8'h32) c = CL_STA;
    else if (op == 8'h0A || op == 8'h1A) c = CL_LDAX;
    else if (op == 8'hC3) c = CL_JMP;
    else if (op == 8'hCD) c = CL_CALL;
    else if (op[7:6] == 2'b00 && op[3:0] == 4'h1) c = CL_LXI;
    else if (op[7:6] == 2'b00 && op[2:0] == 3'b110 && op != 8'h36) c = CL_MVI;
    return c;
  endfunction
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycDone,
  input  logic [DATA_W-1:0] cycRdData,
  output ctl_s              ctl,
  output logic              cycReq,
  output logic [1:0]        cycKind,
  output logic              instrDone
);
  step_e     step, stepNext;
  op_class_e cls, fetchCls;
  logic      useDe, running, lastStep, fire;
  ctl_s      raw;

  assign fetchCls = decodeOp(cycRdData);
  assign fire     = running & cycDone;
  assign cycReq   = running;

  always_comb begin
    raw         = '0;
    raw.addrSel = A_PC;
    raw.wrSel   = W_ACC;
    stepNext    = step;
    lastStep    = 1'b0;
    cycKind     = CYC_READ;
    case (step)
      ST_FETCH: begin
        cycKind   = CYC_FETCH;
        raw.pcInc = 1'b1;
        raw.spDec = (fetchCls == CL_CALL);
        raw.tAdd  = (fetchCls == CL_CALL) ? 3'd6 : 3'd4;
        case (fetchCls)
          CL_MVI, CL_LXI, CL_LDA, CL_STA, CL_JMP: stepNext = ST_OPLO;
          CL_LDAX: stepNext = ST_RPRD;
          CL_CALL: stepNext = ST_PUSHH;
          default: lastStep = 1'b1;
        endcase
      end
      ST_OPLO: begin
        raw.pcInc  = 1'b1;
        raw.opLoLd = 1'b1;
        raw.tAdd   = 3'd3;
        if (cls == CL_MVI) begin
          lastStep = 1'b1;
          stepNext = ST_FETCH;
        end else begin
          stepNext = ST_OPHI;
        end
      end
      ST_OPHI: begin
        raw.opHiLd = 1'b1;
        raw.tAdd   = 3'd3;
        if (cls == CL_JMP || cls == CL_CALL) raw.pcLoad = 1'b1;
        else raw.pcInc = 1'b1;
        if (cls == CL_LDA) stepNext = ST_MEMRD;
        else if (cls == CL_STA) stepNext = ST_MEMWR;
        else begin
          lastStep = 1'b1;
          stepNext = ST_FETCH;
        end
      end
      ST_MEMRD: begin
        raw.addrSel = A_OPND;
        raw.tAdd    = 3'd3;
        lastStep    = 1'b1;
        stepNext    = ST_FETCH;
      end
      ST_MEMWR: begin
        cycKind     = CYC_WRITE;
        raw.addrSel = A_OPND;
        raw.wrSel   = W_ACC;
        raw.tAdd    = 3'd3;
        lastStep    = 1'b1;
        stepNext    = ST_FETCH;
      end
      ST_RPRD: begin
        raw.addrSel = useDe ? A_DE : A_BC;
        raw.tAdd    = 3'd3;
        lastStep    = 1'b1;
        stepNext    = ST_FETCH;
      end
      ST_PUSHH: begin
        cycKind     = CYC_WRITE;
        raw.addrSel = A_SP;
        raw.wrSel   = W_RETHI;
        raw.spDec   = 1'b1;
        raw.tAdd    = 3'd3;
        stepNext    = ST_PUSHL;
      end
      ST_PUSHL: begin
        cycKind     = CYC_WRITE;
        raw.addrSel = A_SP;
        raw.wrSel   = W_RETLO;
        raw.tAdd    = 3'd3;
        stepNext    = ST_OPLO;
      end
      default: stepNext = ST_FETCH;
    endcase
  end

  // Address and data selects always pass; state-changing strobes only on done
  always_comb begin
    ctl        = raw;
    ctl.pcInc  = raw.pcInc & fire;
    ctl.pcLoad = raw.pcLoad & fire;
    ctl.spDec  = raw.spDec & fire;
    ctl.opLoLd = raw.opLoLd & fire;
    ctl.opHiLd = raw.opHiLd & fire;
    ctl.tAdd   = fire ? raw.tAdd : 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step      <= ST_FETCH;
      cls       <= CL_NOP;
      useDe     <= 1'b0;
      running   <= 1'b0;
      instrDone <= 1'b0;
    end else begin
      running   <= 1'b1;
      instrDone <= fire & lastStep;
      if (fire) step <= stepNext;
      if (fire && step == ST_FETCH) begin
        cls   <= fetchCls;
        useDe <= cycRdData[4];
      end
    end
  end
endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import seq_pkg::*;
#(
  parameter int                TCNT_W  = 32,
  parameter logic [ADDR_W-1:0] SP_INIT = 16'h2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  input  logic [DATA_W-1:0] cycRdData,
  input  logic [ADDR_W-1:0] pairBC,
  input  logic [ADDR_W-1:0] pairDE,
  input  logic [DATA_W-1:0] accIn,
  output logic [ADDR_W-1:0] cycAddr,
  output logic [DATA_W-1:0] cycWrData,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut,
  output logic [TCNT_W-1:0] tCount
);
  logic [DATA_W-1:0] opLo, opHi;
  logic [ADDR_W-1:0] retAddr;

  // During the pushes pc points just past the opcode; return skips two operand bytes
  assign retAddr = pcOut + ADDR_W'(2);

  always_comb begin
    case (ctl.addrSel)
      A_OPND:  cycAddr = {opHi, opLo};
      A_BC:    cycAddr = pairBC;
      A_DE:    cycAddr = pairDE;
      A_SP:    cycAddr = spOut;
      default: cycAddr = pcOut;
    endcase
    case (ctl.wrSel)
      W_RETHI: cycWrData = retAddr[ADDR_W-1:DATA_W];
      W_RETLO: cycWrData = retAddr[DATA_W-1:0];
      default: cycWrData = accIn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcOut  <= '0;
      spOut  <= SP_INIT;
      opLo   <= '0;
      opHi   <= '0;
      tCount <= '0;
    end else begin
      if (ctl.pcLoad) pcOut <= {cycRdData, opLo};
      else if (ctl.pcInc) pcOut <= pcOut + ADDR_W'(1);
      if (ctl.spDec) spOut <= spOut - ADDR_W'(1);
      if (ctl.opLoLd) opLo <= cycRdData;
      if (ctl.opHiLd) opHi <= cycRdData;
      tCount <= tCount + TCNT_W'(ctl.tAdd);
    end
  end
endmodule

// File: rtl/bus_cycle_sequencer.sv
module bus_cycle_sequencer
  import seq_pkg::*;
#(
  parameter int                TCNT_W  = 32,
  parameter logic [ADDR_W-1:0] SP_INIT = 16'h2000
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              cycReq,
  output logic [1:0]        cycKind,
  output logic [ADDR_W-1:0] cycAddr,
  output logic [DATA_W-1:0] cycWrData,
  input  logic              cycDone,
  input  logic [DATA_W-1:0] cycRdData,
  input  logic [ADDR_W-1:0] pairBC,
  input  logic [ADDR_W-1:0] pairDE,
  input  logic [DATA_W-1:0] accIn,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut,
  output logic [TCNT_W-1:0] tCount,
  output logic              instrDone
);
  ctl_s ctl;

  seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cycDone(cycDone), .cycRdData(cycRdData),
    .ctl(ctl), .cycReq(cycReq), .cycKind(cycKind), .instrDone(instrDone)
  );

  seq_dpath #(.TCNT_W(TCNT_W), .SP_INIT(SP_INIT)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cycRdData(cycRdData),
    .pairBC(pairBC), .pairDE(pairDE), .accIn(accIn),
    .cycAddr(cycAddr), .cycWrData(cycWrData),
    .pcOut(pcOut), .spOut(spOut), .tCount(tCount)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int TCNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycReq,
  input logic [1:0]        cycKind,
  input logic [15:0]       cycAddr,
  input logic [7:0]        cycWrData,
  input logic              cycDone,
  input logic [15:0]       pcOut,
  input logic [15:0]       spOut,
  input logic [TCNT_W-1:0] tCount,
  input logic              instrDone
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cycReq && !cycDone |=> cycReq && $stable(cycAddr) && $stable(cycKind) && $stable(cycWrData)); // R2

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    cycReq |-> cycKind != 2'd3); // R2

  AST_PC_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    cycReq && cycDone && cycKind == 2'd0 |=> pcOut == $past(pcOut) + 16'd1); // R3

  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (spOut == $past(spOut)) || (spOut == $past(spOut) - 16'd1)); // R10

  AST_TSTATE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tCount == $past(tCount)) || (tCount == $past(tCount) + TCNT_W'(3)) ||
    (tCount == $past(tCount) + TCNT_W'(4)) || (tCount == $past(tCount) + TCNT_W'(6))); // R4

  AST_END_THEN_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    instrDone |-> cycReq && cycKind == 2'd0); // R11
endmodule

bind bus_cycle_sequencer seq_checker #(.TCNT_W(TCNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .cycReq(cycReq), .cycKind(cycKind), .cycAddr(cycAddr),
  .cycWrData(cycWrData), .cycDone(cycDone), .pcOut(pcOut), .spOut(spOut),
  .tCount(tCount), .instrDone(instrDone)
);

// File: tb/bus_cycle_sequencer_tb.sv
module bus_cycle_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycReq, cycDone = 1'b0, instrDone;
  logic [1:0]  cycKind;
  logic [15:0] cycAddr, pcOut, spOut;
  logic [7:0]  cycWrData, cycRdData = 8'h00;
  logic [15:0] pairBC = 16'h1234, pairDE = 16'h5678;
  logic [7:0]  accIn = 8'hA7;
  logic [31:0] tCount;

  int checks = 0, errors = 0;

  typedef struct { logic [1:0] kind; logic [15:0] addr; logic [7:0] wdata; string tag; } cyc_exp_t;
  typedef struct { logic [15:0] pc; logic [15:0] sp; logic [31:0] t; string tag; } ins_exp_t;
  cyc_exp_t cycQ[$];
  ins_exp_t insQ[$];
  logic [7:0] mem [int];

  always #2 clk = ~clk;

  bus_cycle_sequencer dut_i (
    .clk(clk), .rstN(rstN), .cycReq(cycReq), .cycKind(cycKind), .cycAddr(cycAddr),
    .cycWrData(cycWrData), .cycDone(cycDone), .cycRdData(cycRdData),
    .pairBC(pairBC), .pairDE(pairDE), .accIn(accIn), .pcOut(pcOut), .spOut(spOut),
    .tCount(tCount), .instrDone(instrDone)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expCyc(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d, input string tag);
    cyc_exp_t e;
    e.kind = k; e.addr = a; e.wdata = d; e.tag = tag;
    cycQ.push_back(e);
  endtask

  task automatic expIns(input logic [15:0] pc, input logic [15:0] sp, input logic [31:0] t, input string tag);
    ins_exp_t e;
    e.pc = pc; e.sp = sp; e.t = t; e.tag = tag;
    insQ.push_back(e);
  endtask

  // Bus model and cycle monitor: pops expected cycles as the design requests them
  initial begin
    int nCyc = 0;
    forever begin
      @(negedge clk);
      cycDone = 1'b0;
      if (rstN && cycReq && cycQ.size() > 0) begin
        cyc_exp_t e;
        int waitN;
        e = cycQ.pop_front();
        chk({e.tag, " kind"}, 32'(cycKind), 32'(e.kind));
        chk({e.tag, " addr"}, 32'(cycAddr), 32'(e.addr));
        if (e.kind == 2'd2) chk({e.tag, " wdata"}, 32'(cycWrData), 32'(e.wdata));
        waitN = nCyc % 3;
        nCyc++;
        if (waitN > 0) begin
          repeat (waitN) @(negedge clk);
          chk("R2 request held during wait", {14'd0, cycKind, cycAddr}, {14'd0, e.kind, e.addr});
        end
        if (cycKind == 2'd2) mem[int'(cycAddr)] = cycWrData;
        else cycRdData = mem.exists(int'(cycAddr)) ? mem[int'(cycAddr)] : 8'h00;
        cycDone = 1'b1;
      end
    end
  end

  // Instruction-end monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && instrDone) begin
        if (insQ.size() == 0) begin
          chk("R11 unexpected instruction end", 32'd1, 32'd0);
        end else begin
          ins_exp_t e;
          e = insQ.pop_front();
          chk({e.tag, " pc R11"}, 32'(pcOut), 32'(e.pc));
          chk({e.tag, " sp R11"}, 32'(spOut), 32'(e.sp));
          chk({e.tag, " tstates R11"}, tCount, e.t);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    // program image
    mem[0] = 8'h06; mem[1] = 8'h55; mem[2] = 8'h78; mem[3] = 8'h01; mem[4] = 8'h34;
    mem[5] = 8'h12; mem[6] = 8'h3A; mem[7] = 8'h00; mem[8] = 8'h40; mem[9] = 8'h32;
    mem[10] = 8'h10; mem[11] = 8'h40; mem[12] = 8'h0A; mem[13] = 8'h1A; mem[14] = 8'hCD;
    mem[15] = 8'h00; mem[16] = 8'h01; mem['h100] = 8'hFF; mem['h101] = 8'hC3;
    mem['h102] = 8'h00; mem['h103] = 8'h02; mem['h200] = 8'h76;
    mem['h4000] = 8'h99; mem['h1234] = 8'h5A; mem['h5678] = 8'h6B;

    // R5 move immediate
    expCyc(0, 16'h0000, 0, "R5 MVI fetch"); expCyc(1, 16'h0001, 0, "R5 MVI operand");
    expIns(16'h0002, 16'h2000, 7, "R5 MVI");
    // R4 register move
    expCyc(0, 16'h0002, 0, "R4 MOV fetch");
    expIns(16'h0003, 16'h2000, 11, "R4 MOV");
    // R6 load pair immediate
    expCyc(0, 16'h0003, 0, "R6 LXI fetch"); expCyc(1, 16'h0004, 0, "R6 LXI low");
    expCyc(1, 16'h0005, 0, "R6 LXI high");
    expIns(16'h0006, 16'h2000, 21, "R6 LXI");
    // R7 load direct
    expCyc(0, 16'h0006, 0, "R7 LDA fetch"); expCyc(1, 16'h0007, 0, "R7 LDA low");
    expCyc(1, 16'h0008, 0, "R7 LDA high"); expCyc(1, 16'h4000, 0, "R7 LDA data read");
    expIns(16'h0009, 16'h2000, 34, "R7 LDA");
    // R7 store direct
    expCyc(0, 16'h0009, 0, "R7 STA fetch"); expCyc(1, 16'h000A, 0, "R7 STA low");
    expCyc(1, 16'h000B, 0, "R7 STA high"); expCyc(2, 16'h4010, 8'hA7, "R7 STA write");
    expIns(16'h000C, 16'h2000, 47, "R7 STA");
    // R8 indirect loads
    expCyc(0, 16'h000C, 0, "R8 LDAX B fetch"); expCyc(1, 16'h1234, 0, "R8 LDAX B read");
    expIns(16'h000D, 16'h2000, 54, "R8 LDAX B");
    expCyc(0, 16'h000D, 0, "R8 LDAX D fetch"); expCyc(1, 16'h5678, 0, "R8 LDAX D read");
    expIns(16'h000E, 16'h2000, 61, "R8 LDAX D");
    // R10 call: return address 0x0011
    expCyc(0, 16'h000E, 0, "R10 CALL fetch"); expCyc(2, 16'h1FFF, 8'h00, "R10 CALL push high");
    expCyc(2, 16'h1FFE, 8'h11, "R10 CALL push low"); expCyc(1, 16'h000F, 0, "R10 CALL target low");
    expCyc(1, 16'h0010, 0, "R10 CALL target high");
    expIns(16'h0100, 16'h1FFE, 79, "R10 CALL R3");
    // R4 unsupported opcode
    expCyc(0, 16'h0100, 0, "R4 unsupported fetch");
    expIns(16'h0101, 16'h1FFE, 83, "R4 unsupported");
    // R9 jump
    expCyc(0, 16'h0101, 0, "R9 JMP fetch"); expCyc(1, 16'h0102, 0, "R9 JMP low");
    expCyc(1, 16'h0103, 0, "R9 JMP high");
    expIns(16'h0200, 16'h1FFE, 93, "R9 JMP R3");
    expCyc(0, 16'h0200, 0, "R4 halt-as-nop fetch");
    expIns(16'h0201, 16'h1FFE, 97, "R4 halt-as-nop");

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 no request in reset", 32'(cycReq), 32'd0);
    chk("R1 pc reset", 32'(pcOut), 32'h0000);
    chk("R1 sp reset", 32'(spOut), 32'h2000);
    chk("R1 tstates reset", tCount, 32'd0);
    chk("R1 end flag reset", 32'(instrDone), 32'd0);
    rstN = 1'b1;

    while ((cycQ.size() > 0 || insQ.size() > 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 20000) chk("watchdog expired", 32'd1, 32'd0);
    repeat (2) @(negedge clk);
    chk("R7 stored byte", 32'(mem['h4010]), 32'hA7);
    chk("R10 pushed high byte", 32'(mem['h1FFF]), 32'h00);
    chk("R10 pushed low byte", 32'(mem['h1FFE]), 32'h11);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule